// File: doc/BRIEF.md
# Iterative Integer Divider with Condition Flags

This block performs the divide step of a register-based processor. It supports three operand forms, each of which can be signed or unsigned. The word form divides a 32-bit register by a 16-bit divisor and packs the remainder and quotient into one register. The long form divides a 32-bit register by a 32-bit divisor and returns the quotient and the remainder to two separate registers. The quad form divides a 64-bit value, held in a register pair, by a 32-bit divisor.

The surrounding pipeline supplies the following with a single-cycle `start` pulse:
- the register values,
- the divisor,
- the operation form,
- the sign select,
- the two destination indices.

The unit then works on magnitudes with a radix-2 restoring loop and corrects the signs afterwards. It returns write-back requests and condition flags together with a one-cycle `done`, or raises a divide-by-zero trap.

Overflow is judged separately for each form. When it occurs, both registers and the zero and negative flags keep their old values. When the quotient and remainder destinations name the same register, only the quotient is written.

Top module: `divq_unit`

## Requirements
- R1: Form code 00 (word) uses `qreg_val` as the dividend and bits 15:0 of `divisor` as the divisor. It writes `{remainder[15:0], quotient[15:0]}` to `q_idx` and never asserts `r_we`.
- R2: Form code 01 (long) uses `qreg_val` as the dividend and all 32 bits of `divisor`. It writes the quotient to `q_idx` and the remainder to `r_idx`, and `q_widx`/`r_widx` show those indices.
- R3: Form codes 10 and 11 (quad) use `{rreg_val, qreg_val}` as a 64-bit dividend, with `rreg_val` as the upper half. The quotient and remainder go to `q_idx` and `r_idx`.
- R4: With `sgn`=1, the operands are two's complement (a word divisor is sign-extended from bit 15), the quotient truncates toward zero, and the remainder carries the sign of the dividend. With `sgn`=0, the operands are unsigned.
- R5: Overflow is detected as follows:
  - word form: the quotient exceeds 0xFFFF when unsigned, or lies outside -32768..32767 when signed;
  - long and quad forms: the quotient exceeds 32 unsigned bits, or lies outside the signed 32-bit range.
  
  On overflow, `flag_v`=1, neither write enable rises, and `flag_z`/`flag_n` keep their previous values.
- R6: A completion without overflow sets `flag_v`=0, sets `flag_n` to bit 31 of the 32-bit quotient, and sets `flag_z`=1 exactly when that quotient is zero. `flag_c` is 0 at all times.
- R7: A zero divisor raises `dz_trap` together with `done` one clock edge after the edge that sampled `start`. No write enable rises and all flags keep their values. For the word form, only divisor bits 15:0 count.
- R8: In the long and quad forms, when `q_idx` equals `r_idx`, only the quotient is written (`r_we` stays 0).
- R9: `done` lasts exactly one cycle, and write enables are asserted only together with it. A non-trapping operation raises `done` 34 edges after the start edge for the word and long forms, and 66 edges after it for the quad form.
- R10: `busy` is 1 from the edge that samples `start` until `done` rises. A `start` seen while busy is ignored: the running result, its indices and its timing are unchanged.
- R11: After reset, `busy`, `done`, `dz_trap`, both write enables and all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (sampled only when idle) |
| form | input | 2 | 00 word, 01 long, 1x quad |
| sgn | input | 1 | 1 selects signed division |
| qreg_val | input | 32 | Value of the quotient register (dividend, or its low half) |
| rreg_val | input | 32 | Value of the remainder register (dividend high half in quad form) |
| divisor | input | 32 | Divisor operand |
| q_idx | input | 3 | Quotient destination index |
| r_idx | input | 3 | Remainder destination index |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| dz_trap | output | 1 | Divide-by-zero trap, coincident with done |
| q_we | output | 1 | Quotient register write enable |
| q_widx | output | 3 | Quotient write index |
| q_wdata | output | 32 | Quotient write data (packed in word form) |
| r_we | output | 1 | Remainder register write enable |
| r_widx | output | 3 | Remainder write index |
| r_wdata | output | 32 | Remainder write data |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag (always clear) |

## Verification
The quotient write and the remainder write are produced in the same completion cycle. When both name one register, they collide. The collision is provoked by issuing a long operation with equal indices. It is judged by requiring `r_we` low while `q_we` carries the quotient, and a bound property guards the same rule on every completion. A second coincidence is a new `start` arriving while an operation is still running. The bench injects different operands five cycles into a run and checks that the original result, indices and latency survive.

// File: rtl/divq_pkg.sv
package divq_pkg;

    localparam int DIV_W     = 32;
    localparam int HALF_W    = DIV_W / 2;
    localparam int DBL_W     = 2 * DIV_W;
    localparam int CNT_W     = $clog2(DBL_W + 1);
    localparam int REG_IDX_W = 3;

    typedef enum logic [1:0] {
        FORM_WORD     = 2'b00,
        FORM_LONG     = 2'b01,
        FORM_QUAD     = 2'b10,
        FORM_QUAD_ALT = 2'b11
    } div_form_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CHECK,
        ST_RUN,
        ST_FIX
    } div_state_e;

    typedef struct packed {
        div_form_e              form;
        logic                   sgn;
        logic [DIV_W-1:0]       qval;
        logic [DIV_W-1:0]       rval;
        logic [DIV_W-1:0]       dvs;
        logic [REG_IDX_W-1:0]   qidx;
        logic [REG_IDX_W-1:0]   ridx;
    } div_req_t;

    typedef struct packed {
        logic [DBL_W-1:0] dvd_mag;
        logic [DIV_W-1:0] dvs_mag;
        logic             q_neg;
        logic             r_neg;
        logic             dvs_zero;
    } div_ops_t;

    function automatic logic is_quad(div_form_e f);
        return f[1];
    endfunction

    function automatic logic [CNT_W-1:0] iter_count(div_form_e f);
        return f[1] ? CNT_W'(DBL_W) : CNT_W'(DIV_W);
    endfunction

endpackage

// File: rtl/divq_prep.sv
module divq_prep
    import divq_pkg::*;
(
    input  div_req_t req,
    output div_ops_t ops
);
    logic [DBL_W-1:0] dvd_s;
    logic [DIV_W-1:0] dvs_s;
    logic             dvd_neg;
    logic             dvs_neg;

    always_comb begin
        if (is_quad(req.form))
            dvd_s = {req.rval, req.qval};
        else if (req.sgn)
            dvd_s = {{DIV_W{req.qval[DIV_W-1]}}, req.qval};
        else
            dvd_s = {{DIV_W{1'b0}}, req.qval};

        if (req.form == FORM_WORD)
            dvs_s = req.sgn ? {{HALF_W{req.dvs[HALF_W-1]}}, req.dvs[HALF_W-1:0]}
                            : {{HALF_W{1'b0}}, req.dvs[HALF_W-1:0]};
        else
            dvs_s = req.dvs;

        dvd_neg = req.sgn & dvd_s[DBL_W-1];
        dvs_neg = req.sgn & dvs_s[DIV_W-1];

        ops.dvd_mag  = dvd_neg ? -dvd_s : dvd_s;
        ops.dvs_mag  = dvs_neg ? -dvs_s : dvs_s;
        ops.q_neg    = dvd_neg ^ dvs_neg;
        ops.r_neg    = dvd_neg;
        ops.dvs_zero = (dvs_s == '0);
    end
endmodule

// File: rtl/divq_core.sv
module divq_core
    import divq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             step,
    input  logic             quad,
    input  logic [DBL_W-1:0] dvd_in,
    input  logic [DIV_W-1:0] dvs_in,
    output logic [DBL_W-1:0] quo,
    output logic [DIV_W-1:0] rem
);
    logic [DBL_W-1:0] sh_q;
    logic [DIV_W-1:0] r_q;
    logic [DIV_W-1:0] d_q;
    logic [DIV_W:0]   r_sh;
    logic             fits;
    logic [DIV_W-1:0] sub;

    always_comb begin
        r_sh = {r_q, sh_q[DBL_W-1]};
        fits = (r_sh >= {1'b0, d_q});
        sub  = r_sh[DIV_W-1:0] - d_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
            r_q  <= '0;
            d_q  <= '0;
        end else if (load) begin
            sh_q <= quad ? dvd_in : {dvd_in[DIV_W-1:0], {DIV_W{1'b0}}};
            r_q  <= '0;
            d_q  <= dvs_in;
        end else if (step) begin
            sh_q <= {sh_q[DBL_W-2:0], fits};
            r_q  <= fits ? sub : r_sh[DIV_W-1:0];
        end
    end

    assign quo = sh_q;
    assign rem = r_q;
endmodule

// File: rtl/divq_post.sv
module divq_post
    import divq_pkg::*;
(
    input  div_form_e        form,
    input  logic             sgn,
    input  logic             q_neg,
    input  logic             r_neg,
    input  logic [DBL_W-1:0] quo,
    input  logic [DIV_W-1:0] rem,
    output logic [DIV_W-1:0] res_q,
    output logic [DIV_W-1:0] res_r,
    output logic             ovf
);
    logic [DBL_W-1:0] q_full;
    logic [DBL_W-HALF_W:0] w_top;
    logic [DIV_W:0]        l_top;

    always_comb begin
        q_full = q_neg ? -quo : quo;
        res_r  = r_neg ? -rem : rem;
        res_q  = q_full[DIV_W-1:0];
        w_top  = q_full[DBL_W-1:HALF_W-1];
        l_top  = q_full[DBL_W-1:DIV_W-1];
        if (form == FORM_WORD)
            ovf = sgn ? !((&w_top) || !(|w_top)) : |q_full[DBL_W-1:HALF_W];
        else
            ovf = sgn ? !((&l_top) || !(|l_top)) : |q_full[DBL_W-1:DIV_W];
    end
endmodule

// File: rtl/divq_unit.sv
module divq_unit
    import divq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [1:0]           form,
    input  logic                 sgn,
    input  logic [DIV_W-1:0]     qreg_val,
    input  logic [DIV_W-1:0]     rreg_val,
    input  logic [DIV_W-1:0]     divisor,
    input  logic [REG_IDX_W-1:0] q_idx,
    input  logic [REG_IDX_W-1:0] r_idx,
    output logic                 busy,
    output logic                 done,
    output logic                 dz_trap,
    output logic                 q_we,
    output logic [REG_IDX_W-1:0] q_widx,
    output logic [DIV_W-1:0]     q_wdata,
    output logic                 r_we,
    output logic [REG_IDX_W-1:0] r_widx,
    output logic [DIV_W-1:0]     r_wdata,
    output logic                 flag_n,
    output logic                 flag_z,
    output logic                 flag_v,
    output logic                 flag_c
);
    div_state_e       st;
    div_req_t         req_q;
    div_ops_t         ops;
    logic [CNT_W-1:0] cnt;
    logic [DBL_W-1:0] quo;
    logic [DIV_W-1:0] rem;
    logic [DIV_W-1:0] res_q;
    logic [DIV_W-1:0] res_r;
    logic             ovf;
    logic             core_load;
    logic             core_step;

    divq_prep u_prep (
        .req (req_q),
        .ops (ops)
    );

    assign core_load = (st == ST_CHECK) && !ops.dvs_zero;
    assign core_step = (st == ST_RUN);

    divq_core u_core (
        .clk    (clk),
        .rst    (rst),
        .load   (core_load),
        .step   (core_step),
        .quad   (is_quad(req_q.form)),
        .dvd_in (ops.dvd_mag),
        .dvs_in (ops.dvs_mag),
        .quo    (quo),
        .rem    (rem)
    );

    divq_post u_post (
        .form  (req_q.form),
        .sgn   (req_q.sgn),
        .q_neg (ops.q_neg),
        .r_neg (ops.r_neg),
        .quo   (quo),
        .rem   (rem),
        .res_q (res_q),
        .res_r (res_r),
        .ovf   (ovf)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            req_q   <= '0;
            cnt     <= '0;
            done    <= 1'b0;
            dz_trap <= 1'b0;
            q_we    <= 1'b0;
            r_we    <= 1'b0;
            q_wdata <= '0;
            r_wdata <= '0;
            flag_n  <= 1'b0;
            flag_z  <= 1'b0;
            flag_v  <= 1'b0;
        end else begin
            done    <= 1'b0;
            dz_trap <= 1'b0;
            q_we    <= 1'b0;
            r_we    <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (start) begin
                        req_q <= '{form: div_form_e'(form), sgn: sgn, qval: qreg_val,
                                   rval: rreg_val, dvs: divisor, qidx: q_idx, ridx: r_idx};
                        st    <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (ops.dvs_zero) begin
                        done    <= 1'b1;
                        dz_trap <= 1'b1;
                        st      <= ST_IDLE;
                    end else begin
                        cnt <= iter_count(req_q.form);
                        st  <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    cnt <= cnt - CNT_W'(1);
                    if (cnt == CNT_W'(1))
                        st <= ST_FIX;
                end
                ST_FIX: begin
                    done <= 1'b1;
                    st   <= ST_IDLE;
                    if (ovf) begin
                        flag_v <= 1'b1;
                    end else begin
                        flag_v  <= 1'b0;
                        flag_n  <= res_q[DIV_W-1];
                        flag_z  <= (res_q == '0);
                        q_we    <= 1'b1;
                        q_wdata <= (req_q.form == FORM_WORD)
                                   ? {res_r[HALF_W-1:0], res_q[HALF_W-1:0]} : res_q;
                        r_we    <= (req_q.form != FORM_WORD) && (req_q.ridx != req_q.qidx);
                        r_wdata <= res_r;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy   = (st != ST_IDLE);
    assign q_widx = req_q.qidx;
    assign r_widx = req_q.ridx;
    assign flag_c = 1'b0;
endmodule

// File: rtl/divq_checker.sv
module divq_checker
    import divq_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 busy,
    input logic                 done,
    input logic                 dz_trap,
    input logic                 q_we,
    input logic                 r_we,
    input logic [REG_IDX_W-1:0] q_widx,
    input logic [REG_IDX_W-1:0] r_widx,
    input logic                 flag_n,
    input logic                 flag_z,
    input logic                 flag_v
);
    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_we_with_done_R9: assert property (@(posedge clk) disable iff (rst)
        (q_we || r_we) |-> done);

    assert_trap_with_done_R7: assert property (@(posedge clk) disable iff (rst)
        dz_trap |-> done);

    assert_trap_no_write_R7: assert property (@(posedge clk) disable iff (rst)
        dz_trap |-> (!q_we && !r_we));

    assert_no_overflow_write_R5: assert property (@(posedge clk) disable iff (rst)
        (done && flag_v) |-> (!q_we && !r_we));

    assert_ovf_keeps_zn_R5: assert property (@(posedge clk) disable iff (rst)
        (done && flag_v) |-> ($stable(flag_z) && $stable(flag_n)));

    assert_same_index_R8: assert property (@(posedge clk) disable iff (rst)
        (q_we && (q_widx == r_widx)) |-> !r_we);

    assert_done_idle_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
endmodule

bind divq_unit divq_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .busy    (busy),
    .done    (done),
    .dz_trap (dz_trap),
    .q_we    (q_we),
    .r_we    (r_we),
    .q_widx  (q_widx),
    .r_widx  (r_widx),
    .flag_n  (flag_n),
    .flag_z  (flag_z),
    .flag_v  (flag_v)
);

// File: tb/sim_divq_unit.sv
`timescale 1ns/1ps
module sim_divq_unit;

    localparam int NVEC = 18;

    typedef struct packed {
        logic [1:0]  f;
        logic        s;
        logic [31:0] qv;
        logic [31:0] rv;
        logic [31:0] dv;
        logic [2:0]  qi;
        logic [2:0]  ri;
    } vec_t;

    localparam vec_t VEC [NVEC] = '{
        '{2'd0, 1'b0, 32'd100000,     32'd0,          32'd7,          3'd1, 3'd2},
        '{2'd0, 1'b1, 32'hFFFE7960,   32'd0,          32'd7,          3'd1, 3'd2},
        '{2'd0, 1'b1, 32'd7,          32'd0,          32'h0000FFFE,   3'd3, 3'd0},
        '{2'd0, 1'b0, 32'h00100000,   32'd0,          32'd1,          3'd2, 3'd2},
        '{2'd0, 1'b1, 32'd32768,      32'd0,          32'd1,          3'd5, 3'd1},
        '{2'd0, 1'b1, 32'hFFFF8000,   32'd0,          32'd1,          3'd5, 3'd1},
        '{2'd1, 1'b0, 32'hFFFFFFFF,   32'd0,          32'h00000010,   3'd2, 3'd3},
        '{2'd1, 1'b1, 32'h80000000,   32'd0,          32'hFFFFFFFF,   3'd2, 3'd3},
        '{2'd1, 1'b1, 32'hFFFFFFF9,   32'd0,          32'd2,          3'd6, 3'd7},
        '{2'd2, 1'b0, 32'h00000000,   32'h00000001,   32'd2,          3'd0, 3'd1},
        '{2'd2, 1'b0, 32'h00000000,   32'h00000002,   32'd2,          3'd0, 3'd1},
        '{2'd2, 1'b1, 32'h80000000,   32'hFFFFFFFF,   32'd1,          3'd4, 3'd5},
        '{2'd2, 1'b1, 32'h00000000,   32'h80000000,   32'hFFFFFFFF,   3'd4, 3'd5},
        '{2'd1, 1'b0, 32'd100,        32'd0,          32'd7,          3'd4, 3'd4},
        '{2'd3, 1'b0, 32'd5,          32'd0,          32'd9,          3'd1, 3'd2},
        '{2'd0, 1'b0, 32'd50,         32'd0,          32'h00010000,   3'd1, 3'd2},
        '{2'd1, 1'b1, 32'd9,          32'd0,          32'd0,          3'd1, 3'd2},
        '{2'd2, 1'b1, 32'hFFFFFF9B,   32'hFFFFFFFF,   32'hFFFFFFF6,   3'd0, 3'd7}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [1:0]  form;
    logic        sgn;
    logic [31:0] qreg_val, rreg_val, divisor;
    logic [2:0]  q_idx, r_idx;
    logic        busy, done, dz_trap, q_we, r_we;
    logic [2:0]  q_widx, r_widx;
    logic [31:0] q_wdata, r_wdata;
    logic        flag_n, flag_z, flag_v, flag_c;

    int checks = 0;
    int fails  = 0;

    logic        en_exp = 1'b0;
    logic        ez_exp = 1'b0;
    logic        ev_exp = 1'b0;

    always #2 clk = ~clk;

    divq_unit u0 (
        .clk(clk), .rst(rst), .start(start), .form(form), .sgn(sgn),
        .qreg_val(qreg_val), .rreg_val(rreg_val), .divisor(divisor),
        .q_idx(q_idx), .r_idx(r_idx), .busy(busy), .done(done), .dz_trap(dz_trap),
        .q_we(q_we), .q_widx(q_widx), .q_wdata(q_wdata),
        .r_we(r_we), .r_widx(r_widx), .r_wdata(r_wdata),
        .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
    );

    task automatic check(input logic ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL R9 watchdog: actual=timeout expected=completion");
        summary();
        $finish;
    end

    task automatic ref_model(input vec_t v, output logic trap, output logic ovf,
                             output logic qwe, output logic rwe,
                             output logic [31:0] qd, output logic [31:0] rd,
                             output int lat);
        logic [63:0] dd;
        logic [31:0] dvx;
        logic signed [95:0] a, b, q, r;
        dd  = v.f[1] ? {v.rv, v.qv} : (v.s ? {{32{v.qv[31]}}, v.qv} : {32'b0, v.qv});
        dvx = (v.f == 2'b00) ? (v.s ? {{16{v.dv[15]}}, v.dv[15:0]} : {16'b0, v.dv[15:0]}) : v.dv;
        a = v.s ? {{32{dd[63]}}, dd} : {32'b0, dd};
        b = v.s ? {{64{dvx[31]}}, dvx} : {64'b0, dvx};
        trap = (dvx == 32'd0);
        q = '0;
        r = '0;
        if (!trap) begin
            q = a / b;
            r = a % b;
        end
        if (v.f == 2'b00)
            ovf = v.s ? (q > 96'sd32767 || q < -96'sd32768) : (q > 96'sd65535);
        else
            ovf = v.s ? (q > 96'sd2147483647 || q < -96'sd2147483648) : (q > 96'sd4294967295);
        if (trap) ovf = 1'b0;
        qwe = !trap && !ovf;
        rwe = qwe && (v.f != 2'b00) && (v.qi != v.ri);
        qd  = (v.f == 2'b00) ? {r[15:0], q[15:0]} : q[31:0];
        rd  = r[31:0];
        lat = trap ? 1 : (v.f[1] ? 66 : 34);
        if (!trap) begin
            ev_exp = ovf;
            if (!ovf) begin
                en_exp = q[31];
                ez_exp = (q[31:0] == 32'd0);
            end
        end
    endtask

    task automatic drive(input vec_t v);
        form = v.f; sgn = v.s; qreg_val = v.qv; rreg_val = v.rv;
        divisor = v.dv; q_idx = v.qi; r_idx = v.ri;
    endtask

    task automatic wait_done(output int lat);
        lat = 0;
        while (!done && lat < 200) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
    endtask

    initial begin
        rst = 1'b1; start = 1'b0;
        drive('0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11 reset state
        check(!busy && !done && !dz_trap, "R11", "busy/done/trap after reset",
              {61'b0, busy, done, dz_trap}, 64'h0);
        check(!q_we && !r_we, "R11", "write enables after reset", {62'b0, q_we, r_we}, 64'h0);
        check(!flag_n && !flag_z && !flag_v && !flag_c, "R11", "flags after reset",
              {60'b0, flag_n, flag_z, flag_v, flag_c}, 64'h0);

        for (int i = 0; i < NVEC; i++) begin
            vec_t v;
            logic e_trap, e_ovf, e_qwe, e_rwe;
            logic [31:0] e_qd, e_rd;
            int e_lat, lat;
            string tag;
            v = VEC[i];
            ref_model(v, e_trap, e_ovf, e_qwe, e_rwe, e_qd, e_rd, e_lat);
            tag = (v.f == 2'b00) ? "R1" : ((v.f == 2'b01) ? "R2" : "R3");
            if (v.s) tag = {tag, "/R4"};

            @(negedge clk);
            drive(v);
            start = 1'b1;
            @(posedge clk);
            @(negedge clk);
            start = 1'b0;
            check(busy, "R10", "busy after start", {63'b0, busy}, 64'h1);
            wait_done(lat);

            check(lat == e_lat, "R9", "done latency", 64'(lat), 64'(e_lat));
            check(dz_trap == e_trap, "R7", "divide-by-zero trap", {63'b0, dz_trap}, {63'b0, e_trap});
            check(q_we == e_qwe, e_ovf ? "R5" : (e_trap ? "R7" : tag), "quotient write enable",
                  {63'b0, q_we}, {63'b0, e_qwe});
            check(r_we == e_rwe, (v.qi == v.ri) ? "R8" : (e_ovf ? "R5" : tag), "remainder write enable",
                  {63'b0, r_we}, {63'b0, e_rwe});
            if (e_qwe) begin
                check(q_wdata == e_qd, tag, "quotient data", {32'b0, q_wdata}, {32'b0, e_qd});
                check(q_widx == v.qi, "R2", "quotient index", {61'b0, q_widx}, {61'b0, v.qi});
            end
            if (e_rwe) begin
                check(r_wdata == e_rd, tag, "remainder data", {32'b0, r_wdata}, {32'b0, e_rd});
                check(r_widx == v.ri, "R2", "remainder index", {61'b0, r_widx}, {61'b0, v.ri});
            end
            check(flag_v == ev_exp, e_ovf ? "R5" : "R6", "V flag", {63'b0, flag_v}, {63'b0, ev_exp});
            check(flag_n == en_exp && flag_z == ez_exp, e_ovf ? "R5" : (e_trap ? "R7" : "R6"),
                  "N/Z flags", {62'b0, flag_n, flag_z}, {62'b0, en_exp, ez_exp});
            check(!flag_c, "R6", "C flag", {63'b0, flag_c}, 64'h0);
            @(negedge clk);
            check(!done && !q_we && !r_we, "R9", "done/enables one cycle only",
                  {61'b0, done, q_we, r_we}, 64'h0);
        end

        // R10 start while busy is ignored
        begin
            vec_t a, b;
            int lat;
            a = '{2'd1, 1'b0, 32'd1000, 32'd0, 32'd10, 3'd1, 3'd2};
            b = '{2'd2, 1'b1, 32'd999,  32'd5, 32'd3,  3'd6, 3'd6};
            @(negedge clk);
            drive(a);
            start = 1'b1;
            @(posedge clk);
            @(negedge clk);
            start = 1'b0;
            lat = 0;
            while (!done && lat < 200) begin
                @(posedge clk);
                lat++;
                @(negedge clk);
                if (lat == 5) begin
                    check(busy, "R10", "busy mid-run", {63'b0, busy}, 64'h1);
                    drive(b);
                    start = 1'b1;
                end else begin
                    start = 1'b0;
                end
            end
            check(lat == 34, "R10", "latency with ignored start", 64'(lat), 64'd34);
            check(q_we && q_wdata == 32'd100, "R10", "quotient of first request",
                  {32'b0, q_wdata}, 64'd100);
            check(q_widx == 3'd1 && r_we && r_widx == 3'd2, "R10", "indices of first request",
                  {58'b0, q_widx, r_widx}, {58'b0, 3'd1, 3'd2});
            check(!busy, "R10", "idle at done", {63'b0, busy}, 64'h0);
            @(negedge clk);
            check(!busy && !done, "R10", "no second run started", {62'b0, busy, done}, 64'h0);
        end

        summary();
        $finish;
    end
endmodule